// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns one pointer event (three button states and a signed horizontal and vertical motion) into a fixed five-byte packet for a serial mouse link. The bytes go into a small byte queue, and the queue drains through a valid/ready byte stream toward the serializer that follows. An event is offered with a valid strobe. The encoder takes it only while it is idle, so a new event waits until all five bytes of the previous packet have been produced.

The first byte is a header. Its upper bits are fixed and its low three bits are active-low button flags. The second byte is the horizontal motion clamped to a symmetric signed range. The third byte is the vertical motion with its sign flipped, clamped the same way. Two zero bytes close the packet. The queue has a bounded depth. A byte produced while the queue is full is discarded, and nothing upstream is stalled.

Top module: `mouse_pkt_enc`

## Requirements
- R1: After reset, `out_valid` is 0 and `ev_ready` is 1.
- R2: An event is taken on a rising clock edge where `ev_valid` and `ev_ready` are both 1. Exactly five bytes then enter the queue, one per cycle, in the order header, X, Y, zero, zero.
- R3: The header byte is 0x87 with bit 2 cleared when `btn[2]` (left) is 1, bit 1 cleared when `btn[1]` (middle) is 1, and bit 0 cleared when `btn[0]` (right) is 1.
- R4: The X byte is `dx` read as a signed 16-bit value and limited to -127..+127, sent as 8-bit two's complement. The limit is applied to the full-width value, so 0x80 never appears.
- R5: The Y byte is the negation of signed `dy`, limited to -127..+127 the same way. A `dy` of -32768 gives +127.
- R6: The fourth and fifth bytes of every packet are 0x00.
- R7: `ev_ready` is 0 for the five cycles after an event is taken and returns to 1 in the cycle after that.
- R8: The queue holds `QDEPTH` bytes (default 8). A byte produced while the queue is full is dropped, and the bytes already queued are kept in order.
- R9: `out_valid` is 1 whenever the queue is not empty. Bytes leave in the order they entered, one per cycle in which `out_valid` and `out_ready` are both 1. While `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Encoder can take an event |
| dx | input | 16 | Signed horizontal motion |
| dy | input | 16 | Signed vertical motion |
| btn | input | 3 | Buttons: [2] left, [1] middle, [0] right; 1 means pressed |
| out_valid | output | 1 | Queue has a byte |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Byte at the head of the queue |

## Verification
The main sweep crosses all eight button combinations with motion values on and around every clamp boundary (±127, ±128, the 16-bit extremes, zero and ±1), and puts each value on both axes. This separates the clamping of X from the negation and clamping of Y, and it exposes any truncation done before the clamp. A second phase applies irregular back-pressure with the queue kept from filling, which shows whether bytes are held and kept in order. A third phase stalls the consumer across two packets so that the queue overflows partway through the second one. The bench then checks that exactly the bytes that fit come out and nothing after them.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam int PKT_LEN = 5;
  localparam int IDXW = $clog2(PKT_LEN);
  localparam logic [7:0] HDR_BASE = 8'h87;

  // Limit a wide signed value to -127..+127 and return its low byte.
  function automatic logic [7:0] clamp_byte(input logic signed [31:0] v);
    if (v > 32'sd127) return 8'h7F;
    else if (v < -32'sd127) return 8'h81;
    else return v[7:0];
  endfunction

  // Active-low button flags: {left, middle, right} pressed clears {b2, b1, b0}.
  function automatic logic [7:0] header_byte(input logic [2:0] b);
    return HDR_BASE & ~{5'b00000, b};
  endfunction
endpackage

// File: rtl/mpe_packer.sv
module mpe_packer import mpe_pkg::*; #(
  parameter int DXW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ev_valid,
  output logic           ev_ready,
  input  logic [DXW-1:0] dx,
  input  logic [DXW-1:0] dy,
  input  logic [2:0]     btn,
  output logic           push_valid,
  output logic [7:0]     push_data
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(PKT_LEN - 1);

  logic            busy;
  logic [IDXW-1:0] idx;
  logic [7:0]      hdr_q, xb_q, yb_q;

  logic                accept;
  logic                first_byte;
  logic                motion_byte;
  logic                tail_byte;
  logic signed [31:0]  dx_wide;
  logic signed [31:0]  dy_negw;

  assign accept      = ev_valid && ev_ready;
  assign ev_ready    = !busy;
  assign first_byte  = busy && (idx == '0);
  assign motion_byte = busy && (idx == IDXW'(1) || idx == IDXW'(2));
  assign tail_byte   = busy && (idx >= IDXW'(3));
  assign dx_wide     = 32'($signed(dx));
  assign dy_negw     = -(32'($signed(dy)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      hdr_q <= '0;
      xb_q  <= '0;
      yb_q  <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      idx   <= '0;
      hdr_q <= header_byte(btn);
      xb_q  <= clamp_byte(dx_wide);
      yb_q  <= clamp_byte(dy_negw);
    end else if (busy) begin
      if (idx == LAST_IDX) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + IDXW'(1);
      end
    end
  end

  assign push_valid = busy;

  always_comb begin
    case (idx)
      IDXW'(0): push_data = hdr_q;
      IDXW'(1): push_data = xb_q;
      IDXW'(2): push_data = yb_q;
      default:  push_data = 8'h00;
    endcase
  end

  assert_accept_starts_packet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (push_valid && first_byte));
  assert_busy_blocks_events_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ev_ready);
  assert_header_fixed_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    first_byte |-> (push_data[7:3] == 5'b10000));
  assert_motion_never_minus128_R4: assert property (@(posedge clk) disable iff (!rst_n)
    motion_byte |-> (push_data != 8'h80));
  assert_tail_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tail_byte |-> (push_data == 8'h00));
endmodule

// File: rtl/mpe_queue.sv
module mpe_queue #(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_valid,
  input  logic [7:0] push_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  logic full;
  logic do_push;
  logic do_pop;
  logic dropped;

  assign full    = (count == CW'(DEPTH));
  assign do_push = push_valid && !full;
  assign dropped = push_valid && full;
  assign do_pop  = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + AW'(1);
      end
      if (do_pop) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_drop_keeps_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dropped && !do_pop) |=> (count == $past(count)));
  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc #(
  parameter int DXW    = 16,
  parameter int QDEPTH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ev_valid,
  output logic           ev_ready,
  input  logic [DXW-1:0] dx,
  input  logic [DXW-1:0] dy,
  input  logic [2:0]     btn,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [7:0]     out_data
);
  logic       push_valid;
  logic [7:0] push_data;

  mpe_packer #(.DXW(DXW)) u_packer (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_ready(ev_ready),
    .dx(dx), .dy(dy), .btn(btn),
    .push_valid(push_valid), .push_data(push_data)
  );

  mpe_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_data(push_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );
endmodule

// File: tb/mouse_pkt_enc_tb.sv
module mouse_pkt_enc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [15:0] dx = '0, dy = '0;
  logic [2:0]  btn = '0;
  logic        out_valid;
  logic        out_ready;
  logic [7:0]  out_data;

  logic        bp_mode = 1'b0;
  logic        rdy_force = 1'b1;
  int          cyc = 0;
  int          vectors = 0;
  int          fails = 0;
  logic [7:0]  expq[$];
  logic [7:0]  tagq[$];
  bit          done = 0;

  always #2.5 clk = ~clk;

  mouse_pkt_enc u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .dx(dx), .dy(dy), .btn(btn), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    out_ready = bp_mode ? ((cyc % 3) != 1) : rdy_force;
  end

  function automatic logic [7:0] exp_clamp(int v);
    int c;
    c = (v > 127) ? 127 : ((v < -127) ? -127 : v);
    return 8'(c);
  endfunction

  function automatic logic [7:0] exp_hdr(logic [2:0] b);
    int h;
    h = 135;
    if (b[2]) h = h - 4;
    if (b[1]) h = h - 2;
    if (b[0]) h = h - 1;
    return 8'(h);
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Byte monitor: compares every byte leaving the queue against the model.
  logic       pv = 0, pr = 0;
  logic [7:0] pd = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr) check(out_valid && out_data == pd, "R9 hold", {7'd0, out_valid, out_data}, {8'd1, pd});
      if (out_valid && out_ready) begin
        if (expq.size() == 0) check(0, "R8 extra byte", {8'd0, out_data}, 16'hFFFF);
        else begin
          logic [7:0] e;
          logic [7:0] t;
          e = expq.pop_front();
          t = tagq.pop_front();
          case (t)
            8'd0: check(out_data == e, "R3 header", {8'd0, out_data}, {8'd0, e});
            8'd1: check(out_data == e, "R4 x byte", {8'd0, out_data}, {8'd0, e});
            8'd2: check(out_data == e, "R5 y byte", {8'd0, out_data}, {8'd0, e});
            default: check(out_data == e, "R6 zero byte", {8'd0, out_data}, {8'd0, e});
          endcase
        end
      end
      pv = out_valid; pr = out_ready; pd = out_data;
    end
  end

  task automatic expect_packet(logic [2:0] b, int x, int y, int nkeep);
    logic [7:0] bytes [5];
    bytes[0] = exp_hdr(b);
    bytes[1] = exp_clamp(x);
    bytes[2] = exp_clamp(-y);
    bytes[3] = 8'h00;
    bytes[4] = 8'h00;
    for (int k = 0; k < nkeep; k++) begin
      expq.push_back(bytes[k]);
      tagq.push_back(8'(k));
    end
  endtask

  // R2/R7: offer one event, then watch ev_ready through the busy window.
  task automatic send(logic [2:0] b, int x, int y, int nkeep);
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    btn = b; dx = 16'(x); dy = 16'(y); ev_valid = 1'b1;
    expect_packet(b, x, y, nkeep);
    @(negedge clk);
    ev_valid = 1'b0;
    for (int k = 0; k < 5; k++) begin
      check(!ev_ready, "R7 busy", {15'd0, ev_ready}, 16'd0);
      @(negedge clk);
    end
    check(ev_ready, "R7 release", {15'd0, ev_ready}, 16'd1);
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while ((out_valid || expq.size() != 0) && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check(expq.size() == 0, "R2 byte count", 16'(expq.size()), 16'd0);
  endtask

  int vals [12] = '{-32768, -300, -128, -127, -126, -1, 0, 1, 126, 127, 128, 32767};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid, "R1 out_valid", {15'd0, out_valid}, 16'd0);
    check(ev_ready, "R1 ev_ready", {15'd0, ev_ready}, 16'd1);

    // Sweep: buttons x X values, Y taking a rotated value so both axes see all.
    for (int b = 0; b < 8; b++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j += 3)
          send(3'(b), vals[i], vals[(i + j + b) % 12], 5);
    drain();

    // Back-pressure without overflow (R9): wait for empty queue before each event.
    bp_mode = 1'b1;
    for (int i = 0; i < 12; i++) begin
      send(3'(i), vals[11 - i], vals[i], 5);
      drain();
    end
    bp_mode = 1'b0;

    // Overflow (R8): stall, two packets into an 8-byte queue, last two bytes drop.
    rdy_force = 1'b0;
    @(negedge clk);
    send(3'b101, 40, -40, 5);
    send(3'b010, -500, 500, 3);
    repeat (4) @(negedge clk);
    check(out_valid, "R8 full valid", {15'd0, out_valid}, 16'd1);
    rdy_force = 1'b1;
    drain();
    repeat (3) @(negedge clk);
    check(!out_valid, "R8 nothing after drop", {15'd0, out_valid}, 16'd0);

    // Recovery after overflow.
    send(3'b111, -32768, -32768, 5);
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule